// File: doc/BRIEF.md
# SMBus Target Transaction Decoder

This block sits between a byte-level I2C target front end and a register back end. The front end reports what happens on the bus as single-cycle event strobes: a start addressed for writing, a start addressed for reading, a stop, a NACK from the host, a received data byte, and a request for the next byte to transmit. The decoder follows these strobes through a small state machine and works out which SMBus transaction the host performed. The transaction type is inferred from how many bytes were buffered when a stop or a repeated start arrives. The decoder then issues one operation strobe to the back end: a quick command with its direction, a send byte, or a write with a command code and a payload.

On reads, the decoder asks the back end for each byte. A bare read returns one byte. A read that follows a command code returns a stream of bytes at increasing offsets. When the back end supplies nothing, the byte sent is zero. Any event order that SMBus does not allow parks the block in a confused state. In that state it stays silent until the next stop.

The payload buffer holds a command code, a count byte and 32 data bytes. The back end reads payload bytes through an index port while the write operation is presented.

Top module: `smb_txn_decoder`

## Requirements
- R1: A write start in idle enters the write-data state (confused stays low). A write start in any other state makes `confused` high one cycle later.
- R2: A read start in idle enters the receive-byte state. A read start in receive-byte, read-data, done or confused makes `confused` high one cycle later.
- R3: A stop in write-data issues one operation, with `be_op_valid` high one cycle after the stop, selected by the byte count:
  - zero bytes gives kind 0 (quick) with `be_op_rnw`=0;
  - one byte gives kind 1 (send byte), with `be_op_cmd` set to that byte;
  - more bytes give kind 2 (write), with `be_op_cmd` set to the first byte and `be_op_len` set to the count minus one. Payload index i on `be_pl_idx` returns the byte received in position i+1.
- R4: A stop in receive-byte, with no byte requested, issues kind 0 (quick) with `be_op_rnw`=1.
- R5: Every stop returns the block to idle, clears `confused` and empties the buffer. A stop during read-data raises `err_stop_rd` for one cycle. Out of reset, `confused`, `be_op_valid` and `tx_valid` are low.
- R6: A read start in write-data behaves as follows:
  - with zero bytes buffered, it enters confused;
  - with one byte, it latches that byte as the command code and issues no operation;
  - with more bytes, it first issues a kind 2 write operation.
  In the second and third cases the read offset restarts at 0 and the state becomes read-data.
- R7: A byte request in receive-byte fetches with `be_fetch_blk`=0, returns the back-end byte on `tx_data` and moves to done.
- R8: A byte request in read-data fetches with `be_fetch_blk`=1, the latched command code and the current offset. The offset then increments by one.
- R9: `tx_valid` and `tx_data` follow each byte request by one cycle. `tx_data` is 0x00 when the back end gives no valid response. A byte request in idle, write-data, done or confused returns 0x00, issues no fetch and enters confused.
- R10: A host NACK in read-data moves to done. A NACK in done is ignored. A NACK in any other state enters confused.
- R11: A received byte is buffered only in write-data. In any other state it is discarded and `err_drop` pulses one cycle later.
- R12: The buffer holds 34 bytes. A further received byte pulses `err_ovf` and is discarded, so the payload length stays at 33.
- R13: While confused, no operation and no fetch is issued until a stop.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_wr_start | input | 1 | Start (or repeated start) addressed for writing |
| ev_rd_start | input | 1 | Start (or repeated start) addressed for reading |
| ev_stop | input | 1 | Stop condition |
| ev_nack | input | 1 | Host NACKed the last transmitted byte |
| ev_rx_valid | input | 1 | A data byte was received |
| ev_rx_data | input | 8 | The received data byte |
| ev_tx_req | input | 1 | Front end needs the next byte to transmit |
| tx_valid | output | 1 | Byte to transmit is ready |
| tx_data | output | 8 | Byte to transmit |
| be_op_valid | output | 1 | Operation strobe to the back end |
| be_op_kind | output | 2 | 0 quick, 1 send byte, 2 write |
| be_op_rnw | output | 1 | Quick-command direction, 1 = read |
| be_op_cmd | output | 8 | Command code or sent byte |
| be_op_len | output | LEN_W (6) | Payload length of a write |
| be_pl_idx | input | IDX_W (6) | Payload byte index |
| be_pl_data | output | 8 | Payload byte at that index |
| be_fetch | output | 1 | Byte fetch request to the back end |
| be_fetch_blk | output | 1 | 1 = read at command/offset, 0 = receive byte |
| be_fetch_cmd | output | 8 | Command code for the fetch |
| be_fetch_off | output | OFF_W (8) | Byte offset for the fetch |
| be_rsp_valid | input | 1 | Back end answers the fetch in the same cycle |
| be_rsp_data | input | 8 | Back-end byte |
| confused | output | 1 | Illegal event order seen, waiting for stop |
| err_stop_rd | output | 1 | Stop arrived during read-data |
| err_drop | output | 1 | Received byte discarded outside write-data |
| err_ovf | output | 1 | Received byte discarded because the buffer was full |

## Verification
Every registered result is due exactly one cycle after the event strobe that causes it. This covers operation strobes, transmit bytes, error pulses and the confused level. The fetch request and the payload read port are combinational. The bench drives each strobe for one cycle from a falling edge and looks at the results on the next falling edge, which falls within that one-cycle window. Operations and transmit bytes are queued as expected items before their strobe and matched by a monitor on falling edges. The monitor treats any unexpected strobe, or any item left in a queue at the end, as a failure.

// File: rtl/smbtd_pkg.sv
package smbtd_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WRITE,
        ST_RECV,
        ST_READ,
        ST_DONE,
        ST_CONF
    } state_e;

    typedef enum logic [1:0] {
        OP_QUICK = 2'd0,
        OP_SEND  = 2'd1,
        OP_WRITE = 2'd2
    } op_kind_e;

    typedef struct packed {
        op_kind_e           kind;
        logic               rnw;
        logic [BYTE_W-1:0]  cmd;
    } op_t;

    typedef struct packed {
        logic wr_start;
        logic rd_start;
        logic stop;
        logic nack;
        logic rx;
        logic tx_req;
    } evt_t;

    typedef enum logic [2:0] {
        EV_NONE,
        EV_STOP,
        EV_WRS,
        EV_RDS,
        EV_NACK,
        EV_RX,
        EV_TXREQ
    } evsel_e;

    // Strobes are expected one at a time; a stop wins if they collide.
    function automatic evsel_e pick_event(evt_t e);
        if (e.stop)          return EV_STOP;
        else if (e.wr_start) return EV_WRS;
        else if (e.rd_start) return EV_RDS;
        else if (e.nack)     return EV_NACK;
        else if (e.rx)       return EV_RX;
        else if (e.tx_req)   return EV_TXREQ;
        else                 return EV_NONE;
    endfunction

    // Classify a finished write by how many bytes it carried.
    function automatic op_t op_for_write(logic none, logic single, logic [BYTE_W-1:0] first);
        op_t o;
        o.rnw = 1'b0;
        if (none) begin
            o.kind = OP_QUICK;
            o.cmd  = '0;
        end else if (single) begin
            o.kind = OP_SEND;
            o.cmd  = first;
        end else begin
            o.kind = OP_WRITE;
            o.cmd  = first;
        end
        return o;
    endfunction

endpackage

// File: rtl/smbtd_payload_buf.sv
module smbtd_payload_buf
    import smbtd_pkg::*;
#(
    parameter int DEPTH = 34,
    localparam int LEN_W = $clog2(DEPTH + 1),
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              push,
    input  logic [BYTE_W-1:0] din,
    output logic [LEN_W-1:0]  count,
    output logic              ovf,
    output logic [BYTE_W-1:0] first,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [BYTE_W-1:0] rd_data
);

    logic [BYTE_W-1:0] mem [DEPTH];
    logic              full;
    logic [IDX_W:0]    rd_pos;

    assign full = (count == LEN_W'(DEPTH));

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst)
                mem[i] <= '0;
            else if (push && !clr && count == LEN_W'(i))
                mem[i] <= din;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
            ovf   <= 1'b0;
        end else begin
            ovf <= push && full && !clr;
            if (clr)
                count <= '0;
            else if (push && !full)
                count <= count + LEN_W'(1);
        end
    end

    assign first  = mem[0];
    assign rd_pos = {1'b0, rd_idx} + (IDX_W+1)'(1);

    always_comb begin
        if (rd_pos < (IDX_W+1)'(DEPTH))
            rd_data = mem[rd_pos[IDX_W-1:0]];
        else
            rd_data = '0;
    end

    assert_count_bound_R12: assert property (@(posedge clk) disable iff (rst)
        count <= LEN_W'(DEPTH));

    assert_full_discard_R12: assert property (@(posedge clk) disable iff (rst)
        (push && full && !clr) |=> (count == LEN_W'(DEPTH) && ovf));

endmodule

// File: rtl/smbtd_ctrl.sv
module smbtd_ctrl
    import smbtd_pkg::*;
#(
    parameter int LEN_W = 6,
    parameter int OFF_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  evt_t              evt,
    input  logic [LEN_W-1:0]  count,
    input  logic [BYTE_W-1:0] first,
    output logic              buf_push,
    output logic              buf_clr,
    output logic              fetch,
    output logic              fetch_blk,
    output logic [BYTE_W-1:0] fetch_cmd,
    output logic [OFF_W-1:0]  fetch_off,
    output logic              op_valid,
    output op_t               op,
    output logic [LEN_W-1:0]  op_len,
    output logic              confused,
    output logic              err_stop_rd,
    output logic              err_drop
);

    state_e            st, st_n;
    logic [OFF_W-1:0]  off, off_n;
    logic [BYTE_W-1:0] cmd_q, cmd_n;
    logic              op_valid_n, err_stop_n, err_drop_n;
    op_t               op_n;
    logic [LEN_W-1:0]  op_len_n;
    evsel_e            sel;
    logic              cnt_zero, cnt_one;

    assign sel      = pick_event(evt);
    assign cnt_zero = (count == '0);
    assign cnt_one  = (count == LEN_W'(1));

    always_comb begin
        st_n       = st;
        off_n      = off;
        cmd_n      = cmd_q;
        op_valid_n = 1'b0;
        op_n       = '0;
        op_len_n   = '0;
        err_stop_n = 1'b0;
        err_drop_n = 1'b0;
        buf_push   = 1'b0;
        buf_clr    = 1'b0;
        fetch      = 1'b0;
        fetch_blk  = 1'b0;
        unique case (sel)
            EV_STOP: begin
                buf_clr = 1'b1;
                st_n    = ST_IDLE;
                if (st == ST_WRITE) begin
                    op_valid_n = 1'b1;
                    op_n       = op_for_write(cnt_zero, cnt_one, first);
                    if (!cnt_zero && !cnt_one)
                        op_len_n = count - LEN_W'(1);
                end else if (st == ST_RECV) begin
                    op_valid_n = 1'b1;
                    op_n.kind  = OP_QUICK;
                    op_n.rnw   = 1'b1;
                end else if (st == ST_READ) begin
                    err_stop_n = 1'b1;
                end
            end
            EV_WRS: begin
                st_n = (st == ST_IDLE) ? ST_WRITE : ST_CONF;
            end
            EV_RDS: begin
                if (st == ST_IDLE) begin
                    st_n = ST_RECV;
                end else if (st == ST_WRITE && !cnt_zero) begin
                    if (!cnt_one) begin
                        op_valid_n = 1'b1;
                        op_n       = op_for_write(1'b0, 1'b0, first);
                        op_len_n   = count - LEN_W'(1);
                    end
                    cmd_n   = first;
                    off_n   = '0;
                    buf_clr = 1'b1;
                    st_n    = ST_READ;
                end else begin
                    st_n = ST_CONF;
                end
            end
            EV_NACK: begin
                if (st == ST_READ)
                    st_n = ST_DONE;
                else if (st != ST_DONE)
                    st_n = ST_CONF;
            end
            EV_RX: begin
                if (st == ST_WRITE)
                    buf_push = 1'b1;
                else
                    err_drop_n = 1'b1;
            end
            EV_TXREQ: begin
                if (st == ST_RECV) begin
                    fetch = 1'b1;
                    st_n  = ST_DONE;
                end else if (st == ST_READ) begin
                    fetch     = 1'b1;
                    fetch_blk = 1'b1;
                    off_n     = off + OFF_W'(1);
                end else begin
                    st_n = ST_CONF;
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st          <= ST_IDLE;
            off         <= '0;
            cmd_q       <= '0;
            op_valid    <= 1'b0;
            op          <= '0;
            op_len      <= '0;
            err_stop_rd <= 1'b0;
            err_drop    <= 1'b0;
        end else begin
            st          <= st_n;
            off         <= off_n;
            cmd_q       <= cmd_n;
            op_valid    <= op_valid_n;
            op          <= op_n;
            op_len      <= op_len_n;
            err_stop_rd <= err_stop_n;
            err_drop    <= err_drop_n;
        end
    end

    assign fetch_cmd = cmd_q;
    assign fetch_off = off;
    assign confused  = (st == ST_CONF);

    assert_stop_idle_R5: assert property (@(posedge clk) disable iff (rst)
        evt.stop |=> (st == ST_IDLE && !op_valid || st == ST_IDLE));

    assert_wrstart_busy_R1: assert property (@(posedge clk) disable iff (rst)
        (sel == EV_WRS && st != ST_IDLE) |=> confused);

    assert_rstart_empty_R6: assert property (@(posedge clk) disable iff (rst)
        (sel == EV_RDS && st == ST_WRITE && cnt_zero) |=> confused);

    assert_offset_step_R8: assert property (@(posedge clk) disable iff (rst)
        (fetch && fetch_blk) |=> (off == OFF_W'($past(off) + OFF_W'(1))));

    assert_conf_silent_R13: assert property (@(posedge clk) disable iff (rst)
        (st == ST_CONF && !evt.stop) |=> (!op_valid && !$past(fetch)));

    assert_nack_done_R10: assert property (@(posedge clk) disable iff (rst)
        (sel == EV_NACK && st == ST_DONE) |=> (st == ST_DONE));

endmodule

// File: rtl/smbtd_txpath.sv
module smbtd_txpath
    import smbtd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tx_req,
    input  logic              fetch,
    input  logic              rsp_valid,
    input  logic [BYTE_W-1:0] rsp_data,
    output logic              tx_valid,
    output logic [BYTE_W-1:0] tx_data
);

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_valid <= 1'b0;
            tx_data  <= '0;
        end else begin
            tx_valid <= tx_req;
            tx_data  <= (tx_req && fetch && rsp_valid) ? rsp_data : '0;
        end
    end

    assert_tx_zero_R9: assert property (@(posedge clk) disable iff (rst)
        (tx_req && !(fetch && rsp_valid)) |=> (tx_valid && tx_data == '0));

    assert_tx_follow_R9: assert property (@(posedge clk) disable iff (rst)
        tx_valid |-> $past(tx_req));

endmodule

// File: rtl/smb_txn_decoder.sv
module smb_txn_decoder
    import smbtd_pkg::*;
#(
    parameter int BUF_DEPTH = 34,
    parameter int OFF_W     = 8,
    localparam int LEN_W    = $clog2(BUF_DEPTH + 1),
    localparam int IDX_W    = $clog2(BUF_DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ev_wr_start,
    input  logic              ev_rd_start,
    input  logic              ev_stop,
    input  logic              ev_nack,
    input  logic              ev_rx_valid,
    input  logic [7:0]        ev_rx_data,
    input  logic              ev_tx_req,
    output logic              tx_valid,
    output logic [7:0]        tx_data,
    output logic              be_op_valid,
    output logic [1:0]        be_op_kind,
    output logic              be_op_rnw,
    output logic [7:0]        be_op_cmd,
    output logic [LEN_W-1:0]  be_op_len,
    input  logic [IDX_W-1:0]  be_pl_idx,
    output logic [7:0]        be_pl_data,
    output logic              be_fetch,
    output logic              be_fetch_blk,
    output logic [7:0]        be_fetch_cmd,
    output logic [OFF_W-1:0]  be_fetch_off,
    input  logic              be_rsp_valid,
    input  logic [7:0]        be_rsp_data,
    output logic              confused,
    output logic              err_stop_rd,
    output logic              err_drop,
    output logic              err_ovf
);

    evt_t              evt;
    logic              buf_push, buf_clr;
    logic [LEN_W-1:0]  buf_count;
    logic [BYTE_W-1:0] buf_first;
    op_t               op;

    assign evt = '{wr_start: ev_wr_start, rd_start: ev_rd_start, stop: ev_stop,
                   nack: ev_nack, rx: ev_rx_valid, tx_req: ev_tx_req};

    smbtd_payload_buf #(.DEPTH(BUF_DEPTH)) u_buf (
        .clk     (clk),
        .rst     (rst),
        .clr     (buf_clr),
        .push    (buf_push),
        .din     (ev_rx_data),
        .count   (buf_count),
        .ovf     (err_ovf),
        .first   (buf_first),
        .rd_idx  (be_pl_idx),
        .rd_data (be_pl_data)
    );

    smbtd_ctrl #(.LEN_W(LEN_W), .OFF_W(OFF_W)) u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .evt         (evt),
        .count       (buf_count),
        .first       (buf_first),
        .buf_push    (buf_push),
        .buf_clr     (buf_clr),
        .fetch       (be_fetch),
        .fetch_blk   (be_fetch_blk),
        .fetch_cmd   (be_fetch_cmd),
        .fetch_off   (be_fetch_off),
        .op_valid    (be_op_valid),
        .op          (op),
        .op_len      (be_op_len),
        .confused    (confused),
        .err_stop_rd (err_stop_rd),
        .err_drop    (err_drop)
    );

    smbtd_txpath u_tx (
        .clk       (clk),
        .rst       (rst),
        .tx_req    (ev_tx_req),
        .fetch     (be_fetch),
        .rsp_valid (be_rsp_valid),
        .rsp_data  (be_rsp_data),
        .tx_valid  (tx_valid),
        .tx_data   (tx_data)
    );

    assign be_op_kind = op.kind;
    assign be_op_rnw  = op.rnw;
    assign be_op_cmd  = op.cmd;

endmodule

// File: tb/smb_txn_decoder_bench.sv
module smb_txn_decoder_bench;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 200000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ev_wr_start = 0, ev_rd_start = 0, ev_stop = 0, ev_nack = 0;
    logic       ev_rx_valid = 0, ev_tx_req = 0;
    logic [7:0] ev_rx_data = 0;
    logic       tx_valid;
    logic [7:0] tx_data;
    logic       be_op_valid, be_op_rnw;
    logic [1:0] be_op_kind;
    logic [7:0] be_op_cmd;
    logic [5:0] be_op_len;
    logic [5:0] be_pl_idx = 0;
    logic [7:0] be_pl_data;
    logic       be_fetch, be_fetch_blk;
    logic [7:0] be_fetch_cmd, be_fetch_off;
    logic       be_rsp_valid;
    logic [7:0] be_rsp_data;
    logic       confused, err_stop_rd, err_drop, err_ovf;
    logic       rsp_en = 1'b1;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    logic [16:0] exp_op_q[$];
    string       op_tag_q[$];
    logic [7:0]  exp_tx_q[$];
    string       tx_tag_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    // Back-end model: receive byte gives A5, read gives cmd + offset.
    assign be_rsp_valid = be_fetch & rsp_en;
    assign be_rsp_data  = be_fetch_blk ? (be_fetch_cmd + be_fetch_off) : 8'hA5;

    smb_txn_decoder u_smb_txn_decoder (
        .clk(clk), .rst(rst),
        .ev_wr_start(ev_wr_start), .ev_rd_start(ev_rd_start), .ev_stop(ev_stop),
        .ev_nack(ev_nack), .ev_rx_valid(ev_rx_valid), .ev_rx_data(ev_rx_data),
        .ev_tx_req(ev_tx_req), .tx_valid(tx_valid), .tx_data(tx_data),
        .be_op_valid(be_op_valid), .be_op_kind(be_op_kind), .be_op_rnw(be_op_rnw),
        .be_op_cmd(be_op_cmd), .be_op_len(be_op_len), .be_pl_idx(be_pl_idx),
        .be_pl_data(be_pl_data), .be_fetch(be_fetch), .be_fetch_blk(be_fetch_blk),
        .be_fetch_cmd(be_fetch_cmd), .be_fetch_off(be_fetch_off),
        .be_rsp_valid(be_rsp_valid), .be_rsp_data(be_rsp_data),
        .confused(confused), .err_stop_rd(err_stop_rd), .err_drop(err_drop),
        .err_ovf(err_ovf)
    );

    function automatic logic [16:0] mk_op(logic [1:0] k, logic rnw, logic [7:0] c, logic [5:0] l);
        return {k, rnw, c, l};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic push_op(input string tag, input logic [16:0] o);
        exp_op_q.push_back(o);
        op_tag_q.push_back(tag);
    endtask

    task automatic push_tx(input string tag, input logic [7:0] b);
        exp_tx_q.push_back(b);
        tx_tag_q.push_back(tag);
    endtask

    // Called at a falling edge; pulses one strobe for one cycle.
    // codes: 0 wr start, 1 rd start, 2 stop, 3 nack, 4 rx, 5 tx request
    task automatic ev(input int which, input logic [7:0] d);
        case (which)
            0: ev_wr_start = 1;
            1: ev_rd_start = 1;
            2: ev_stop     = 1;
            3: ev_nack     = 1;
            4: begin ev_rx_valid = 1; ev_rx_data = d; end
            default: ev_tx_req = 1;
        endcase
        @(negedge clk);
        ev_wr_start = 0; ev_rd_start = 0; ev_stop = 0;
        ev_nack = 0; ev_rx_valid = 0; ev_tx_req = 0;
    endtask

    // Scoreboard monitor
    always @(negedge clk) begin
        if (!rst && !finished) begin
            if (be_op_valid) begin
                if (exp_op_q.size() == 0) begin
                    checks++; errors++;
                    $display("FAIL R13 unexpected op actual=%0h expected=none",
                             {be_op_kind, be_op_rnw, be_op_cmd, be_op_len});
                end else begin
                    automatic logic [16:0] e = exp_op_q.pop_front();
                    automatic string t = op_tag_q.pop_front();
                    chk(t, {15'd0, be_op_kind, be_op_rnw, be_op_cmd, be_op_len}, {15'd0, e});
                end
            end
            if (tx_valid) begin
                if (exp_tx_q.size() == 0) begin
                    checks++; errors++;
                    $display("FAIL R9 unexpected tx actual=%0h expected=none", tx_data);
                end else begin
                    automatic logic [7:0] e = exp_tx_q.pop_front();
                    automatic string t = tx_tag_q.pop_front();
                    chk(t, {24'd0, tx_data}, {24'd0, e});
                end
            end
        end
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!finished) begin
            finished = 1;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R5 reset confused", {31'd0, confused}, 0);
        chk("R5 reset op_valid", {31'd0, be_op_valid}, 0);
        chk("R5 reset tx_valid", {31'd0, tx_valid}, 0);
        rst = 0;
        @(negedge clk);

        // R3 quick write
        push_op("R3 quick write", mk_op(2'd0, 1'b0, 8'h00, 6'd0));
        ev(0, 0);
        chk("R1 write start in idle", {31'd0, confused}, 0);
        ev(2, 0);

        // R4 quick read
        push_op("R4 quick read", mk_op(2'd0, 1'b1, 8'h00, 6'd0));
        ev(1, 0); ev(2, 0);

        // R3 send byte
        push_op("R3 send byte", mk_op(2'd1, 1'b0, 8'h3C, 6'd0));
        ev(0, 0); ev(4, 8'h3C); ev(2, 0);

        // R3 write word
        push_op("R3 write word", mk_op(2'd2, 1'b0, 8'h10, 6'd2));
        ev(0, 0); ev(4, 8'h10); ev(4, 8'h22); ev(4, 8'h33); ev(2, 0);
        be_pl_idx = 0; #1 chk("R3 payload 0", {24'd0, be_pl_data}, 32'h22);
        be_pl_idx = 1; #1 chk("R3 payload 1", {24'd0, be_pl_data}, 32'h33);
        @(negedge clk);

        // R7 receive byte, R10 nack in done ignored, R9 request in done
        push_tx("R7 receive byte", 8'hA5);
        ev(1, 0); ev(5, 0);
        ev(3, 0);
        chk("R10 nack in done ignored", {31'd0, confused}, 0);
        push_tx("R9 request in done", 8'h00);
        ev(5, 0);
        chk("R9 request in done confuses", {31'd0, confused}, 1);
        ev(2, 0);
        chk("R5 stop clears confused", {31'd0, confused}, 0);

        // R6 one byte then repeated start, R8 offsets, R10 nack in read
        push_tx("R8 read offset 0", 8'h40);
        push_tx("R8 read offset 1", 8'h41);
        ev(0, 0); ev(4, 8'h40); ev(1, 0);
        chk("R6 one-byte restart not confused", {31'd0, confused}, 0);
        ev(5, 0); ev(5, 0);
        ev(3, 0);
        chk("R10 nack in read", {31'd0, confused}, 0);
        ev(2, 0);
        chk("R5 stop in done no error", {31'd0, err_stop_rd}, 0);

        // R6 multi-byte write then read; R5 stop during read
        push_op("R6 write before read", mk_op(2'd2, 1'b0, 8'h50, 6'd2));
        push_tx("R8 read after write", 8'h50);
        ev(0, 0); ev(4, 8'h50); ev(4, 8'h01); ev(4, 8'h02); ev(1, 0);
        ev(5, 0);
        ev(2, 0);
        chk("R5 stop in read flags", {31'd0, err_stop_rd}, 1);

        // R6 empty restart, R11 drop, R13 silent, R9 zero
        ev(0, 0); ev(1, 0);
        chk("R6 empty restart confuses", {31'd0, confused}, 1);
        ev(4, 8'h77);
        chk("R11 drop in confused", {31'd0, err_drop}, 1);
        push_tx("R13 no fetch while confused", 8'h00);
        ev(5, 0);
        ev(3, 0);
        chk("R13 still confused", {31'd0, confused}, 1);
        ev(2, 0);
        chk("R5 stop after confused", {31'd0, confused}, 0);

        // R1 write start in receive-byte
        ev(1, 0); ev(0, 0);
        chk("R1 write start busy", {31'd0, confused}, 1);
        ev(2, 0);

        // R2 read start in done
        push_tx("R7 receive before restart", 8'hA5);
        ev(1, 0); ev(5, 0); ev(1, 0);
        chk("R2 read start in done", {31'd0, confused}, 1);
        ev(2, 0);

        // R10 nack in write-data
        ev(0, 0); ev(3, 0);
        chk("R10 nack in write", {31'd0, confused}, 1);
        ev(2, 0);

        // R9 back end silent
        rsp_en = 0;
        push_tx("R9 no response gives zero", 8'h00);
        ev(0, 0); ev(4, 8'h60); ev(1, 0); ev(5, 0); ev(2, 0);
        rsp_en = 1;

        // R11 byte in idle
        ev(4, 8'h12);
        chk("R11 drop in idle", {31'd0, err_drop}, 1);

        // R12 overflow
        push_op("R12 full write", mk_op(2'd2, 1'b0, 8'h70, 6'd33));
        ev(0, 0);
        chk("R11 drop clears", {31'd0, err_drop}, 0);
        ev(4, 8'h70);
        for (int k = 1; k <= 33; k++) ev(4, 8'h80 + 8'(k));
        chk("R12 no overflow at 34", {31'd0, err_ovf}, 0);
        ev(4, 8'hEE);
        chk("R12 overflow flag", {31'd0, err_ovf}, 1);
        ev(2, 0);
        be_pl_idx = 32; #1 chk("R12 last payload", {24'd0, be_pl_data}, 32'hA1);
        be_pl_idx = 0;  #1 chk("R12 first payload", {24'd0, be_pl_data}, 32'h81);

        repeat (4) @(negedge clk);
        chk("R13 op queue drained", exp_op_q.size(), 0);
        chk("R9 tx queue drained", exp_tx_q.size(), 0);
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule